// File: doc/BRIEF.md
# Round-Robin Channel Scheduler

This block shares a single block-compression pipeline between three colour planes: luma (Y), blue-difference chroma (Cb) and red-difference chroma (Cr). Each plane's block buffer raises a ready flag when a full block is waiting. The scheduler walks the planes in a fixed order, Y first, then Cb, then Cr, and passes over any plane that has no block waiting.

For each plane it serves, the scheduler places the plane's code on a channel-select output and picks the quantization table that suits that plane. In one cycle it pulses a read strobe to that plane's buffer together with a pipeline start. It then holds its selection until the pipeline reports completion, and only after that does it move on to the next plane. After the last plane it goes back to idle and begins the next round with Y. A global enable stops all of this activity.

Top module: `rr_chan_sched`

## Requirements
- R1: After reset, pipeStart and readEn are 0, and chanSel and tableSel are both 2'b00.
- R2: chanSel names the plane being served: 2'b00 for Y, 2'b01 for Cb, 2'b10 for Cr.
- R3: tableSel is 2'b00 (luminance table) when Y is served and 2'b01 (chroma table) when Cb or Cr is served.
- R4: Planes are considered in the fixed order Y, Cb, Cr. After Cr the scheduler goes idle and the next round starts again at Y.
- R5: A plane whose ready bit is low when its turn comes is skipped in that round without waiting. A round with no ready plane issues no start.
- R6: readEn has one bit per plane (bit 0 Y, bit 1 Cb, bit 2 Cr). Only the served plane's bit pulses, for exactly one cycle, in the same cycle as pipeStart. pipeStart is a single-cycle pulse.
- R7: After a start, no further start is issued until pipeDone is seen. chanSel and tableSel stay constant from the start until pipeDone.
- R8: While enable is low, no start or read pulse is issued and the scheduler returns to idle with chanSel at 2'b00. When enable rises again, the next round begins at Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Global scheduling enable |
| blkReady | input | 3 | Per-plane block-ready flags (bit 0 Y, 1 Cb, 2 Cr) |
| pipeDone | input | 1 | Pipeline finished the current block |
| chanSel | output | 2 | Code of the plane being served |
| tableSel | output | 2 | Quantization table choice |
| readEn | output | 3 | One-cycle read strobe to the served buffer |
| pipeStart | output | 1 | One-cycle pipeline start |

## Verification
The assertions check four things on every cycle: the read strobe is at most one-hot and matches the select code at a start, the table choice agrees with the plane at a start, pulses are a single cycle long and never follow a low enable, and the selection does not move while a block is in flight. Some behaviour can only be shown by the bench's scenarios, because it concerns sequences: the order in which planes are served under every combination of ready flags, the skipping of idle planes, the wrap from Cr back to Y, and the restart at Y after enable is withdrawn in the middle of a block. The bench sweeps all eight ready patterns against several pipeline latencies.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PICK   = 2'd1,
    ST_LAUNCH = 2'd2,
    ST_WAIT   = 2'd3
  } schedState_t;

  // strobes from control to the index datapath
  typedef struct packed {
    logic clearIdx;
    logic stepIdx;
    logic launch;
  } idxCmd_t;
endpackage

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sched_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    enable,
  input  logic    curReady,
  input  logic    lastCh,
  input  logic    pipeDone,
  output idxCmd_t cmd,
  output logic    pipeStart
);
  schedState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState    = state;
    cmd          = '0;
    if (!enable) begin
      nextState    = ST_IDLE;
      cmd.clearIdx = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cmd.clearIdx = 1'b1;
          nextState    = ST_PICK;
        end
        ST_PICK: begin
          if (curReady) begin
            nextState = ST_LAUNCH;
          end else begin
            cmd.stepIdx = 1'b1;
            nextState   = lastCh ? ST_IDLE : ST_PICK;
          end
        end
        ST_LAUNCH: begin
          cmd.launch = 1'b1;
          nextState  = ST_WAIT;
        end
        ST_WAIT: begin
          if (pipeDone) begin
            cmd.stepIdx = 1'b1;
            nextState   = lastCh ? ST_IDLE : ST_PICK;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  assign pipeStart = cmd.launch;
endmodule

// File: rtl/sched_dpath.sv
module sched_dpath
  import sched_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int TBL_W    = 2,
  parameter int LUMA_TBL = 0,
  parameter int CHR_TBL  = 1,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  idxCmd_t           cmd,
  input  logic [NUM_CH-1:0] blkReady,
  output logic              curReady,
  output logic              lastCh,
  output logic [CH_W-1:0]   chanSel,
  output logic [TBL_W-1:0]  tableSel,
  output logic [NUM_CH-1:0] readEn
);
  localparam logic [CH_W-1:0] LAST_IDX = CH_W'(NUM_CH - 1);

  logic [CH_W-1:0]   idx;
  logic [NUM_CH-1:0] readyHit;

  always_ff @(posedge clk) begin
    if (rst || cmd.clearIdx)  idx <= '0;
    else if (cmd.stepIdx)     idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign readyHit[g] = blkReady[g] && (idx == CH_W'(g));
    assign readEn[g]   = cmd.launch && (idx == CH_W'(g));
  end

  assign curReady = |readyHit;
  assign lastCh   = (idx == LAST_IDX);
  assign chanSel  = idx;
  assign tableSel = (idx == '0) ? TBL_W'(LUMA_TBL) : TBL_W'(CHR_TBL);
endmodule

// File: rtl/rr_chan_sched.sv
module rr_chan_sched
  import sched_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [NUM_CH-1:0] blkReady,
  input  logic              pipeDone,
  output logic [1:0]        chanSel,
  output logic [1:0]        tableSel,
  output logic [NUM_CH-1:0] readEn,
  output logic              pipeStart
);
  idxCmd_t cmd;
  logic    curReady;
  logic    lastCh;

  sched_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .curReady (curReady),
    .lastCh   (lastCh),
    .pipeDone (pipeDone),
    .cmd      (cmd),
    .pipeStart(pipeStart)
  );

  sched_dpath #(.NUM_CH(NUM_CH), .TBL_W(2)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .blkReady (blkReady),
    .curReady (curReady),
    .lastCh   (lastCh),
    .chanSel  (chanSel),
    .tableSel (tableSel),
    .readEn   (readEn)
  );
endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic [NUM_CH-1:0] blkReady,
  input logic              pipeDone,
  input logic [1:0]        chanSel,
  input logic [1:0]        tableSel,
  input logic [NUM_CH-1:0] readEn,
  input logic              pipeStart
);
  logic inFlight;

  always_ff @(posedge clk) begin
    if (rst)                        inFlight <= 1'b0;
    else if (!enable || pipeDone)   inFlight <= 1'b0;
    else if (pipeStart)             inFlight <= 1'b1;
  end

  assert_read_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(readEn));

  assert_read_matches_sel_R6: assert property (@(posedge clk) disable iff (rst)
    pipeStart |-> (readEn == (NUM_CH'(1) << chanSel)));

  assert_start_single_R6: assert property (@(posedge clk) disable iff (rst)
    pipeStart |=> !pipeStart);

  assert_table_choice_R3: assert property (@(posedge clk) disable iff (rst)
    pipeStart |-> (tableSel == ((chanSel == 2'd0) ? 2'd0 : 2'd1)));

  assert_sel_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (inFlight && enable && !pipeDone) |=> ($stable(chanSel) && $stable(tableSel)));

  assert_no_restart_R7: assert property (@(posedge clk) disable iff (rst)
    (inFlight && !pipeDone) |-> !pipeStart);

  assert_enable_gate_R8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !pipeStart);
endmodule

bind rr_chan_sched sched_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/test_rr_chan_sched.sv
module test_rr_chan_sched;
  logic       clk = 1'b0;
  logic       rst;
  logic       enable;
  logic [2:0] blkReady;
  logic       pipeDone;
  logic [1:0] chanSel;
  logic [1:0] tableSel;
  logic [2:0] readEn;
  logic       pipeStart;

  int testsRun = 0;
  int testsFailed = 0;

  always #4 clk = ~clk;

  rr_chan_sched i_rr_chan_sched (
    .clk(clk), .rst(rst), .enable(enable), .blkReady(blkReady),
    .pipeDone(pipeDone), .chanSel(chanSel), .tableSel(tableSel),
    .readEn(readEn), .pipeStart(pipeStart)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nextCh(input logic [2:0] pat, input int prev);
    for (int k = 1; k <= 3; k++) begin
      if (pat[(prev + k) % 3]) return (prev + k) % 3;
    end
    return -1;
  endfunction

  // wait for a start; returns 1 if one came within the limit
  task automatic waitStart(output bit got);
    got = 1'b0;
    for (int c = 0; c < 40 && !got; c++) begin
      @(negedge clk);
      if (pipeStart) got = 1'b1;
      else if (readEn != 3'b000) check(1'b0, "R6 strobe without start", readEn, 0);
    end
  endtask

  task automatic serveOne(input int expCh, input int lat);
    bit got;
    waitStart(got);
    check(got, "R4/R5 start issued", got, 1);
    if (!got) return;
    check(chanSel == 2'(expCh), "R2/R4/R5 chanSel", chanSel, expCh);
    check(tableSel == ((expCh == 0) ? 2'd0 : 2'd1), "R3 tableSel", tableSel,
          (expCh == 0) ? 0 : 1);
    check(readEn == (3'b001 << expCh), "R6 readEn", readEn, 1 << expCh);
    for (int c = 0; c < lat; c++) begin
      @(negedge clk);
      check(!pipeStart && readEn == 3'b000, "R6/R7 no pulse while busy",
            {pipeStart, readEn}, 0);
      check(chanSel == 2'(expCh), "R7 chanSel held", chanSel, expCh);
    end
    pipeDone = 1'b1;
    @(negedge clk);
    pipeDone = 1'b0;
  endtask

  task automatic runPattern(input logic [2:0] pat, input int lat);
    int prev = 2;
    bit hit;
    enable = 1'b0;
    repeat (3) @(negedge clk);
    blkReady = pat;
    enable = 1'b1;
    if (pat == 3'b000) begin
      hit = 1'b0;
      repeat (30) begin
        @(negedge clk);
        if (pipeStart || readEn != 3'b000) hit = 1'b1;
      end
      check(!hit, "R5 no start when nothing ready", hit, 0);
      return;
    end
    for (int n = 0; n < 6; n++) begin
      int e = nextCh(pat, prev);
      serveOne(e, lat);
      prev = e;
    end
  endtask

  initial begin
    rst = 1'b1; enable = 1'b0; blkReady = 3'b111; pipeDone = 1'b0;
    repeat (3) @(negedge clk);
    check(!pipeStart && readEn == 3'b000, "R1 pulses idle in reset", {pipeStart, readEn}, 0);
    check(chanSel == 2'd0 && tableSel == 2'd0, "R1 selects in reset", {chanSel, tableSel}, 0);
    rst = 1'b0;
    begin
      bit hit = 1'b0;
      repeat (10) begin
        @(negedge clk);
        if (pipeStart || readEn != 3'b000) hit = 1'b1;
      end
      check(!hit, "R8 disabled with all ready", hit, 0);
    end

    for (int lat = 1; lat <= 4; lat++)
      for (int p = 0; p < 8; p++)
        runPattern(3'(p), lat);

    // R8: withdraw enable in the middle of a block, then resume at Y
    enable = 1'b0;
    repeat (3) @(negedge clk);
    blkReady = 3'b111;
    enable = 1'b1;
    serveOne(0, 2);
    begin
      bit got;
      bit hit = 1'b0;
      waitStart(got);
      check(got && chanSel == 2'd1, "R4 Cb after Y", chanSel, 1);
      @(negedge clk);
      enable = 1'b0;
      repeat (8) begin
        @(negedge clk);
        if (pipeStart || readEn != 3'b000) hit = 1'b1;
      end
      check(!hit, "R8 no pulses while disabled", hit, 0);
      check(chanSel == 2'd0, "R8 idle select", chanSel, 0);
      enable = 1'b1;
      serveOne(0, 1);
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule